// File: doc/BRIEF.md
# Directory-Coherent Cache Line Controller

This block is the cache side of a directory coherence scheme with no shared bus. It holds a small direct-mapped array of lines. Each line is Invalid, Shared (read-only) or Exclusive (read/write). When a processor access cannot complete in the array, the controller sends an explicit point-to-point message to the home directory of the block. It also answers three kinds of request that arrive from the home: invalidate, fetch, and fetch-with-invalidate. Each outgoing message carries this node's processor number, a block address and, for write-backs, the full block of data.

The processor raises a request and holds it, with its address and write data unchanged, until `cpu_done_o` pulses. Hits finish in the cycle they are presented. A miss leaves the controller in one of two ways. It may send a single miss message. If an Exclusive line with another tag is being displaced, it first sends that line's write-back and then the miss. The controller then waits for the home's data reply, which carries the whole block. After the fill the access completes as a hit.

Only one miss is in flight at a time. The home is assumed to deliver messages in order and not to probe this node while its miss is outstanding. Probes that arrive while the controller is busy are held in a single slot and served once the controller is idle.

Top module: `coh_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, `msg_valid_o` and `cpu_done_o` are low, and the first access of any kind misses.
- R2: A read that misses sends one message of kind 0 (read miss) carrying the processor number and the block address (word address without the word-offset bits). After the home's data reply (kind 3) the line is Shared and the access completes returning the addressed word of the reply block.
- R3: A write to a line that is Invalid or Shared sends a message of kind 1 (write miss). The reply fills the full block, the written word is merged into it, and the line becomes Exclusive.
- R4: A read of a Shared or Exclusive line with a matching tag, or a write of an Exclusive line, completes with `cpu_done_o` in the cycle it is presented and sends no message.
- R5: An invalidate (home kind 0) for a matching Shared line makes it Invalid. An invalidate for a line that is Exclusive, Invalid or holds another tag changes nothing.
- R6: A fetch (home kind 1) for a matching Exclusive line sends a write-back (kind 2) with the block address and the line's current data. The line then stays readable as Shared.
- R7: A fetch-with-invalidate (home kind 2) for a matching Exclusive line sends a write-back (kind 2) with the line's data and leaves the line Invalid.
- R8: A fetch or fetch-with-invalidate for a line that is not Exclusive with a matching tag sends no message and leaves the line unchanged.
- R9: A miss whose index holds an Exclusive line of another tag first sends that line's write-back (its own block address and data), then the read or write miss. Displacing a Shared line sends only the miss.
- R10: An outgoing message keeps valid, kind, address and data unchanged until accepted with `msg_ready_i`. No new message is issued while a miss awaits its reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor access request, held until done |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address: tag, line index, word offset |
| cpu_wdata_i | input | WORD_W | Write data |
| cpu_done_o | output | 1 | Access completes this cycle |
| cpu_rdata_o | output | WORD_W | Read data, valid with done |
| msg_valid_o | output | 1 | Outgoing message valid |
| msg_ready_i | input | 1 | Network accepts the outgoing message |
| msg_kind_o | output | 2 | 0 read miss, 1 write miss, 2 write-back |
| msg_proc_o | output | PID_W | This node's processor number |
| msg_blk_o | output | ADDR_W-log2(WORDS) | Block address |
| msg_data_o | output | WORDS*WORD_W | Block data (write-back) |
| home_valid_i | input | 1 | Incoming home message valid, one cycle |
| home_kind_i | input | 2 | 0 invalidate, 1 fetch, 2 fetch-invalidate, 3 data reply |
| home_blk_i | input | ADDR_W-log2(WORDS) | Block address of the home message |
| home_data_i | input | WORDS*WORD_W | Block data of a data reply |

## Verification
A line left in the wrong state does not show at once. It shows on the next access or probe that touches the same index, as a surplus or missing message, or as a hit that completes in a later cycle than the one it was presented in. A corrupted line shows as a wrong read word or a wrong write-back payload. The bench therefore tracks a model of every line and of home memory. It follows each probe with accesses to the same index, so that a dropped or extra state change appears within a few operations. It compares every message's kind, block, processor number and payload. Random back-pressure on the message port also exposes any change in a message's fields while it waits to be accepted.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    OM_RD_MISS   = 2'd0,
    OM_WR_MISS   = 2'd1,
    OM_WRITEBACK = 2'd2
  } out_msg_e;

  typedef enum logic [1:0] {
    HM_INVAL     = 2'd0,
    HM_FETCH     = 2'd1,
    HM_FETCH_INV = 2'd2,
    HM_DATA      = 2'd3
  } home_msg_e;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_MISS = 2'd1,
    F_WAIT = 2'd2
  } ctl_st_e;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int unsigned LINES    = 4,
  parameter int unsigned IDX_W    = 2,
  parameter int unsigned TAG_W    = 8,
  parameter int unsigned BLK_BITS = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [TAG_W-1:0]    rd_tag_o,
  output line_st_e            rd_st_o,
  output logic [BLK_BITS-1:0] rd_data_o,
  input  logic [IDX_W-1:0]    inv_idx_i,
  output logic [TAG_W-1:0]    inv_tag_o,
  output line_st_e            inv_st_o,
  input  logic                inv_en_i,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [TAG_W-1:0]    wr_tag_i,
  input  line_st_e            wr_st_i,
  input  logic [BLK_BITS-1:0] wr_data_i
);
  line_st_e [LINES-1:0]                st_all;
  logic     [LINES-1:0][TAG_W-1:0]     tag_all;
  logic     [LINES-1:0][BLK_BITS-1:0]  dat_all;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    line_st_e            st_q;
    logic [TAG_W-1:0]    tag_q;
    logic [BLK_BITS-1:0] dat_q;
    logic                wr_sel, inv_sel;

    assign wr_sel  = wr_en_i && (wr_idx_i == IDX_W'(i));
    assign inv_sel = inv_en_i && (inv_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q  <= LS_INV;
        tag_q <= '0;
        dat_q <= '0;
      end else if (wr_sel) begin
        st_q  <= wr_st_i;
        tag_q <= wr_tag_i;
        dat_q <= wr_data_i;
      end else if (inv_sel) begin
        st_q  <= LS_INV;
      end
    end

    assign st_all[i]  = st_q;
    assign tag_all[i] = tag_q;
    assign dat_all[i] = dat_q;
  end

  assign rd_tag_o  = tag_all[rd_idx_i];
  assign rd_st_o   = st_all[rd_idx_i];
  assign rd_data_o = dat_all[rd_idx_i];
  assign inv_tag_o = tag_all[inv_idx_i];
  assign inv_st_o  = st_all[inv_idx_i];

  // an invalidate not overridden by a same-line write leaves the line Invalid
  p_inval_drops_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_en_i && !(wr_en_i && wr_idx_i == inv_idx_i)) |=> st_all[$past(inv_idx_i)] == LS_INV);
endmodule

// File: rtl/coh_msg_out.sv
module coh_msg_out #(
  parameter int unsigned BLK_W    = 10,
  parameter int unsigned BLK_BITS = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [1:0]          kind_i,
  input  logic [BLK_W-1:0]    blk_i,
  input  logic [BLK_BITS-1:0] data_i,
  output logic                free_o,
  output logic                valid_o,
  input  logic                ready_i,
  output logic [1:0]          kind_o,
  output logic [BLK_W-1:0]    blk_o,
  output logic [BLK_BITS-1:0] data_o
);
  logic vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      kind_o <= '0;
      blk_o  <= '0;
      data_o <= '0;
    end else if (load_i && !vld_q) begin
      vld_q  <= 1'b1;
      kind_o <= kind_i;
      blk_o  <= blk_i;
      data_o <= data_i;
    end else if (vld_q && ready_i) begin
      vld_q  <= 1'b0;
    end
  end

  assign valid_o = vld_q;
  assign free_o  = !vld_q;

  p_hold_until_taken_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(kind_o) && $stable(blk_o) && $stable(data_o)));

  p_load_when_free_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !valid_o);
endmodule

// File: rtl/coh_cache_ctrl.sv
module coh_cache_ctrl
  import coh_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned WORDS   = 4,
  parameter int unsigned LINES   = 4,
  parameter int unsigned PID_W   = 4,
  parameter int unsigned PROC_ID = 3,
  localparam int unsigned OFF_W    = $clog2(WORDS),
  localparam int unsigned BLK_W    = ADDR_W - OFF_W,
  localparam int unsigned BLK_BITS = WORDS * WORD_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cpu_req_i,
  input  logic                cpu_we_i,
  input  logic [ADDR_W-1:0]   cpu_addr_i,
  input  logic [WORD_W-1:0]   cpu_wdata_i,
  output logic                cpu_done_o,
  output logic [WORD_W-1:0]   cpu_rdata_o,
  output logic                msg_valid_o,
  input  logic                msg_ready_i,
  output logic [1:0]          msg_kind_o,
  output logic [PID_W-1:0]    msg_proc_o,
  output logic [BLK_W-1:0]    msg_blk_o,
  output logic [BLK_BITS-1:0] msg_data_o,
  input  logic                home_valid_i,
  input  logic [1:0]          home_kind_i,
  input  logic [BLK_W-1:0]    home_blk_i,
  input  logic [BLK_BITS-1:0] home_data_i
);
  localparam int unsigned IDX_W = $clog2(LINES);
  localparam int unsigned TAG_W = BLK_W - IDX_W;

  logic [BLK_W-1:0] cpu_blk;
  logic [IDX_W-1:0] cpu_idx;
  logic [TAG_W-1:0] cpu_tag;
  logic [OFF_W-1:0] cpu_off;

  assign cpu_blk = cpu_addr_i[ADDR_W-1:OFF_W];
  assign cpu_idx = cpu_blk[IDX_W-1:0];
  assign cpu_tag = cpu_blk[BLK_W-1:IDX_W];
  assign cpu_off = cpu_addr_i[OFF_W-1:0];

  ctl_st_e fsm_q, fsm_d;

  // single slot for a pending fetch / fetch-invalidate
  logic             prb_q, prb_inv_q, prb_clr;
  logic [BLK_W-1:0] prb_blk_q;

  logic [IDX_W-1:0]    rd_idx;
  logic [TAG_W-1:0]    rd_tag, inv_tag;
  line_st_e            rd_st, inv_st;
  logic [BLK_BITS-1:0] rd_data;

  logic                wr_en, inv_en;
  logic [IDX_W-1:0]    wr_idx;
  logic [TAG_W-1:0]    wr_tag;
  line_st_e            wr_st;
  logic [BLK_BITS-1:0] wr_data;

  logic                out_load, out_free;
  out_msg_e            out_kind;
  logic [BLK_W-1:0]    out_blk;

  logic hit, reply;

  assign rd_idx = (fsm_q == F_IDLE && prb_q) ? prb_blk_q[IDX_W-1:0] : cpu_idx;

  assign hit = cpu_req_i && fsm_q == F_IDLE && !prb_q && rd_tag == cpu_tag &&
               rd_st != LS_INV && (!cpu_we_i || rd_st == LS_EXC);

  assign reply = fsm_q == F_WAIT && home_valid_i && home_kind_i == HM_DATA &&
                 home_blk_i == cpu_blk;

  assign cpu_done_o  = hit;
  assign cpu_rdata_o = rd_data[cpu_off*WORD_W +: WORD_W];

  assign inv_en = home_valid_i && home_kind_i == HM_INVAL &&
                  inv_tag == home_blk_i[BLK_W-1:IDX_W] && inv_st == LS_SHR;

  always_comb begin
    fsm_d    = fsm_q;
    prb_clr  = 1'b0;
    out_load = 1'b0;
    out_kind = OM_RD_MISS;
    out_blk  = cpu_blk;
    wr_en    = 1'b0;
    wr_idx   = rd_idx;
    wr_tag   = rd_tag;
    wr_st    = rd_st;
    wr_data  = rd_data;
    unique case (fsm_q)
      F_IDLE: begin
        if (prb_q) begin
          if (out_free) begin
            prb_clr = 1'b1;
            if (rd_tag == prb_blk_q[BLK_W-1:IDX_W] && rd_st == LS_EXC) begin
              out_load = 1'b1;
              out_kind = OM_WRITEBACK;
              out_blk  = prb_blk_q;
              wr_en    = 1'b1;
              wr_st    = prb_inv_q ? LS_INV : LS_SHR;
            end
          end
        end else if (hit) begin
          if (cpu_we_i) begin
            wr_en = 1'b1;
            wr_st = LS_EXC;
            wr_data[cpu_off*WORD_W +: WORD_W] = cpu_wdata_i;
          end
        end else if (cpu_req_i && out_free) begin
          out_load = 1'b1;
          if (rd_st == LS_EXC && rd_tag != cpu_tag) begin
            // displaced owner line goes home first
            out_kind = OM_WRITEBACK;
            out_blk  = {rd_tag, cpu_idx};
            wr_en    = 1'b1;
            wr_st    = LS_INV;
            fsm_d    = F_MISS;
          end else begin
            out_kind = cpu_we_i ? OM_WR_MISS : OM_RD_MISS;
            fsm_d    = F_WAIT;
          end
        end
      end
      F_MISS: begin
        if (out_free) begin
          out_load = 1'b1;
          out_kind = cpu_we_i ? OM_WR_MISS : OM_RD_MISS;
          fsm_d    = F_WAIT;
        end
      end
      F_WAIT: begin
        if (reply) begin
          wr_en   = 1'b1;
          wr_idx  = cpu_idx;
          wr_tag  = cpu_tag;
          wr_st   = cpu_we_i ? LS_EXC : LS_SHR;
          wr_data = home_data_i;
          fsm_d   = F_IDLE;
        end
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q     <= F_IDLE;
      prb_q     <= 1'b0;
      prb_inv_q <= 1'b0;
      prb_blk_q <= '0;
    end else begin
      fsm_q <= fsm_d;
      if (prb_clr) prb_q <= 1'b0;
      if (home_valid_i && (home_kind_i == HM_FETCH || home_kind_i == HM_FETCH_INV)) begin
        prb_q     <= 1'b1;
        prb_inv_q <= home_kind_i == HM_FETCH_INV;
        prb_blk_q <= home_blk_i;
      end
    end
  end

  coh_line_store #(
    .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .BLK_BITS(BLK_BITS)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (rd_idx),
    .rd_tag_o  (rd_tag),
    .rd_st_o   (rd_st),
    .rd_data_o (rd_data),
    .inv_idx_i (home_blk_i[IDX_W-1:0]),
    .inv_tag_o (inv_tag),
    .inv_st_o  (inv_st),
    .inv_en_i  (inv_en),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_tag_i  (wr_tag),
    .wr_st_i   (wr_st),
    .wr_data_i (wr_data)
  );

  coh_msg_out #(.BLK_W(BLK_W), .BLK_BITS(BLK_BITS)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (out_load),
    .kind_i  (out_kind),
    .blk_i   (out_blk),
    .data_i  (rd_data),
    .free_o  (out_free),
    .valid_o (msg_valid_o),
    .ready_i (msg_ready_i),
    .kind_o  (msg_kind_o),
    .blk_o   (msg_blk_o),
    .data_o  (msg_data_o)
  );

  assign msg_proc_o = PID_W'(PROC_ID);

  p_one_miss_outstanding_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsm_q == F_WAIT |-> !out_load);

  p_hit_sends_nothing_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |-> (!out_load && fsm_q == F_IDLE));

  p_writeback_from_owner_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_load && out_kind == OM_WRITEBACK) |-> rd_st == LS_EXC);

  p_fill_then_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reply |=> (cpu_done_o || prb_q || !cpu_req_i));
endmodule

// File: tb/coh_cache_ctrl_tb.sv
`timescale 1ns/1ps
module coh_cache_ctrl_tb;
  localparam int CLK_NS = 20;
  localparam logic [1:0] M_RD = 2'd0, M_WR = 2'd1, M_WB = 2'd2;
  localparam logic [1:0] H_INV = 2'd0, H_F = 2'd1, H_FI = 2'd2, H_DATA = 2'd3;
  localparam logic [1:0] S_I = 2'd0, S_S = 2'd1, S_E = 2'd2;
  localparam logic [3:0] MY_PID = 4'd3;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        cpu_req, cpu_we;
  logic [11:0] cpu_addr;
  logic [15:0] cpu_wdata;
  logic        cpu_done;
  logic [15:0] cpu_rdata;
  logic        msg_valid, msg_ready;
  logic [1:0]  msg_kind;
  logic [3:0]  msg_proc;
  logic [9:0]  msg_blk;
  logic [63:0] msg_data;
  logic        home_valid;
  logic [1:0]  home_kind;
  logic [9:0]  home_blk;
  logic [63:0] home_data;

  always #(CLK_NS/2) clk = ~clk;

  coh_cache_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_done_o(cpu_done), .cpu_rdata_o(cpu_rdata),
    .msg_valid_o(msg_valid), .msg_ready_i(msg_ready), .msg_kind_o(msg_kind),
    .msg_proc_o(msg_proc), .msg_blk_o(msg_blk), .msg_data_o(msg_data),
    .home_valid_i(home_valid), .home_kind_i(home_kind), .home_blk_i(home_blk),
    .home_data_i(home_data)
  );

  int checks = 0, fails = 0;

  // line model and home memory
  logic [1:0]  mst [4];
  logic [7:0]  mtag[4];
  logic [63:0] mdat[4];
  logic [63:0] mem [int];

  // captured messages
  logic [1:0]  cap_kind[8];
  logic [9:0]  cap_blk [8];
  logic [63:0] cap_data[8];
  logic [3:0]  cap_proc[8];
  int          ncap;
  bit          done_seen, stall_pend, stall_mode;
  logic [15:0] rd_cap;
  logic [75:0] stall_snap;
  int          pend_reply;
  logic [9:0]  rblk;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_get(input logic [9:0] b);
    if (mem.exists(int'(b))) return mem[int'(b)];
    return {6'h28, b, 6'h2c, b, 6'h30, b, 6'h34, b};
  endfunction

  function automatic logic [11:0] ad(input int tg, input int ix, input int off);
    return {8'(tg), 2'(ix), 2'(off)};
  endfunction

  // inputs already driven at posedge+1; sample, then advance one cycle
  task automatic tick();
    #1;
    if (stall_pend) begin
      chk(msg_valid && {msg_kind, msg_blk, msg_data} == stall_snap, "R10", "held message",
          {msg_valid, msg_kind, msg_blk, msg_data[49:0]}, {1'b1, stall_snap[63:0]});
      stall_pend = 0;
    end
    if (cpu_done) begin
      done_seen = 1;
      rd_cap = cpu_rdata;
    end
    if (msg_valid && msg_ready) begin
      if (ncap < 8) begin
        cap_kind[ncap] = msg_kind; cap_blk[ncap] = msg_blk;
        cap_data[ncap] = msg_data; cap_proc[ncap] = msg_proc;
      end
      ncap++;
      if (msg_kind == M_WB) mem[int'(msg_blk)] = msg_data;
      else begin rblk = msg_blk; pend_reply = 2; end
    end else if (msg_valid) begin
      stall_pend = 1;
      stall_snap = {msg_kind, msg_blk, msg_data};
    end
    @(posedge clk); #1;
  endtask

  task automatic check_msgs(input string req, input int nexp, input logic [1:0] k0,
                            input logic [9:0] b0, input logic [63:0] d0,
                            input logic [1:0] k1, input logic [9:0] b1);
    chk(ncap == nexp, req, "message count", 64'(ncap), 64'(nexp));
    if (ncap == nexp && nexp > 0) begin
      chk(cap_kind[0] == k0 && cap_blk[0] == b0 && cap_proc[0] == MY_PID, req, "msg0 kind/blk/proc",
          {cap_kind[0], cap_blk[0], cap_proc[0]}, {k0, b0, MY_PID});
      if (k0 == M_WB) chk(cap_data[0] == d0, req, "write-back data", cap_data[0], d0);
      if (nexp > 1)
        chk(cap_kind[1] == k1 && cap_blk[1] == b1 && cap_proc[1] == MY_PID, req, "msg1 kind/blk/proc",
            {cap_kind[1], cap_blk[1], cap_proc[1]}, {k1, b1, MY_PID});
    end
  endtask

  task automatic access(input bit we, input logic [11:0] a, input logic [15:0] wd);
    logic [9:0] blk; logic [1:0] ix; logic [7:0] tg; logic [1:0] off;
    bit hit, victim; string req; int cyc, done_at, nexp;
    logic [1:0] mk;
    blk = a[11:2]; ix = blk[1:0]; tg = blk[9:2]; off = a[1:0];
    hit    = mst[ix] != S_I && mtag[ix] == tg && (!we || mst[ix] == S_E);
    victim = mst[ix] == S_E && mtag[ix] != tg;
    req = hit ? "R4" : victim ? "R9" : we ? "R3" : "R2";
    mk  = we ? M_WR : M_RD;
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    done_seen = 0; ncap = 0; pend_reply = -1; stall_pend = 0; cyc = 0; done_at = -1;
    while (!done_seen && cyc < 80) begin
      msg_ready = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
      if (pend_reply == 0) begin
        home_valid = 1; home_kind = H_DATA; home_blk = rblk; home_data = mem_get(rblk);
      end else home_valid = 0;
      if (pend_reply >= 0) pend_reply--;
      tick();
      if (done_seen) done_at = cyc;
      cyc++;
    end
    cpu_req = 0; home_valid = 0; msg_ready = 0;
    chk(done_seen, req, "access completes", 64'(done_seen), 64'd1);
    if (hit) begin
      chk(done_at == 0, "R4", "hit completes in presenting cycle", 64'(done_at), 64'd0);
      nexp = 0;
    end else nexp = victim ? 2 : 1;
    if (victim) check_msgs(req, nexp, M_WB, {mtag[ix], ix}, mdat[ix], mk, blk);
    else        check_msgs(req, nexp, mk, blk, 64'd0, 2'd0, 10'd0);
    if (!hit) begin
      mdat[ix] = mem_get(blk); mtag[ix] = tg; mst[ix] = we ? S_E : S_S;
    end
    if (we) mdat[ix][off*16 +: 16] = wd;
    else chk(rd_cap == mdat[ix][off*16 +: 16], req, "read word", 64'(rd_cap),
             64'(mdat[ix][off*16 +: 16]));
  endtask

  task automatic home_send(input logic [1:0] k, input logic [9:0] b);
    logic [1:0] ix; bit match; string req; int nexp; logic [63:0] dexp;
    ix = b[1:0];
    match = mst[ix] != S_I && mtag[ix] == b[9:2];
    nexp = 0; dexp = mdat[ix];
    if (k == H_INV) begin
      req = "R5";
      if (match && mst[ix] == S_S) mst[ix] = S_I;
    end else if (match && mst[ix] == S_E) begin
      req = (k == H_F) ? "R6" : "R7";
      nexp = 1;
      mst[ix] = (k == H_F) ? S_S : S_I;
    end else req = "R8";
    ncap = 0; pend_reply = -1; stall_pend = 0;
    msg_ready = 1;
    home_valid = 1; home_kind = k; home_blk = b; home_data = '0;
    tick();
    home_valid = 0;
    for (int i = 0; i < 6; i++) tick();
    msg_ready = 0;
    check_msgs(req, nexp, M_WB, b, dexp, 2'd0, 10'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin mst[i] = S_I; mtag[i] = '0; mdat[i] = '0; end
    rst_ni = 0; cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
    msg_ready = 0; home_valid = 0; home_kind = '0; home_blk = '0; home_data = '0;
    stall_mode = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(posedge clk); #2;
    chk(!msg_valid && !cpu_done, "R1", "idle outputs after reset",
        {62'd0, msg_valid, cpu_done}, 64'd0);
    #(CLK_NS - 1);

    access(0, ad(1, 0, 1), 16'h0);        // R1/R2 first access misses
    access(0, ad(1, 0, 2), 16'h0);        // R4 read hit in Shared
    access(1, ad(1, 0, 2), 16'h1234);     // R3 upgrade from Shared
    access(1, ad(1, 0, 3), 16'h5678);     // R4 write hit in Exclusive
    access(0, ad(1, 0, 2), 16'h0);        // R4 merged word readable
    home_send(H_F, {8'd1, 2'd0});         // R6
    access(0, ad(1, 0, 3), 16'h0);        // still readable after fetch
    home_send(H_F, {8'd1, 2'd0});         // R8 fetch on Shared ignored
    home_send(H_INV, {8'd1, 2'd0});       // R5
    access(0, ad(1, 0, 0), 16'h0);        // misses again, memory holds written data
    access(1, ad(2, 1, 0), 16'haaaa);     // R3 write from Invalid
    home_send(H_INV, {8'd2, 2'd1});       // R5 ignored on Exclusive
    access(1, ad(2, 1, 1), 16'hbbbb);     // hit proves line kept
    home_send(H_FI, {8'd2, 2'd1});        // R7
    access(1, ad(2, 1, 0), 16'hcccc);     // write miss again
    access(0, ad(3, 1, 0), 16'h0);        // R9 displaces Exclusive
    access(0, ad(4, 1, 2), 16'h0);        // R9 displaces Shared: miss only
    home_send(H_FI, {8'd9, 2'd2});        // R8 nothing cached
    home_send(H_INV, {8'd7, 2'd1});       // R5 other tag ignored
    access(0, ad(4, 1, 3), 16'h0);

    stall_mode = 1;                       // R10 back-pressure from here on
    for (int n = 0; n < 300; n++) begin
      int r, i;
      r = $urandom_range(0, 9);
      if (r < 6) access($urandom_range(0, 1) == 1,
                        ad($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3)),
                        16'($urandom()));
      else begin
        i = $urandom_range(0, 3);
        if ($urandom_range(0, 1) == 1) home_send(2'($urandom_range(0, 2)), {mtag[i], 2'(i)});
        else home_send(2'($urandom_range(0, 2)), {8'($urandom_range(0, 3)), 2'(i)});
      end
    end
    report();
  end
endmodule